// File: doc/BRIEF.md
# Event Interrupt Aggregator with End-of-Interrupt Re-arm

This block gathers per-endpoint transmit and receive events and nine core-level bus events into one 32-bit raw source register, and drives a single interrupt request toward the CPU. Software reaches it over a simple register bus with a write strobe, a byte address and write data. Reads return data combinationally. Source bits and mask bits each have their own write-one-to-set and write-one-to-clear registers, so software can raise, acknowledge, enable or disable single bits without a read-modify-write. A further register returns the source ANDed with the mask.

The interrupt request is gated by an armed flag. While the flag is set, the request is high whenever any unmasked source bit is pending. Once the request has been high for a cycle, the flag drops. The request then stays low, whatever else arrives, until software writes the end-of-interrupt register. A one-cycle soft reset, started through the control register, returns the source, the mask and the armed flag to their reset values.

Top module: `irq_agg_top`

## Requirements
- R1: Hardware events set raw source bits (read at offset 0x20) in fixed positions: `tx_evt[4:0]` at bits 4:0, `rx_evt[3:0]` at bits 12:9, `core_evt[8:0]` at bits 16 to 24, with bit 24 being the VBUS-drive change event. All other bits, including bit 8, always read 0.
- R2: Writing offset 0x24 sets every implemented source bit that is 1 in the write data. Zero bits leave the source unchanged.
- R3: Writing offset 0x28 clears every source bit that is 1 in the write data. A hardware event on the same bit in the same cycle wins, so that bit ends up set.
- R4: Writing offset 0x30 sets, and writing offset 0x34 clears, the mask bits that are 1 in the write data, limited to implemented bit positions. The mask reads back at offset 0x2c. Writes to 0x20 and 0x2c have no effect.
- R5: Offset 0x38 reads as the raw source ANDed with the mask.
- R6: `irq_out` is high when the block is armed and the masked source is nonzero. After one high cycle the block disarms and `irq_out` stays low until a write of any data to offset 0x3c re-arms it.
- R7: Writing 1 to bit 0 of offset 0x04 makes that bit read 1 for exactly one cycle. At the end of that cycle, the source and mask become zero and the block is armed; events and writes during that cycle are dropped.
- R8: Offset 0x00 reads the nonzero constant `REV_ID`. Bit 0 of offset 0x08 reads the live `vbus_drv` input, and its other bits read 0. The set, clear and end-of-interrupt offsets and all unmapped offsets read 0.
- R9: After `rst_n` is released, the source and mask are zero, the block is armed, and `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tx_evt | input | 5 | Transmit endpoint event pulses |
| rx_evt | input | 4 | Receive endpoint event pulses |
| core_evt | input | 9 | Core-level event pulses |
| vbus_drv | input | 1 | VBUS-drive level, visible in the status register |
| irq_out | output | 1 | Interrupt request to the CPU |

## Verification
The hardest situation to reach from the ports is the quiet window. In that window pending masked bits are still present and new events keep arriving, but `irq_out` must stay low until the end-of-interrupt write. The window only opens after the request has fired. Directed steps therefore fire the request, inject further events with the mask open, and then re-arm. A seeded random phase keeps end-of-interrupt writes rare, which leaves long disarmed stretches. The random phase also sometimes issues a clear on the same cycle as an event on the same bit.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DW       = 32;
  localparam int AW       = 8;
  localparam int TX_N     = 5;
  localparam int TX_LSB   = 0;
  localparam int RX_N     = 4;
  localparam int RX_LSB   = 9;
  localparam int CORE_N   = 9;
  localparam int CORE_LSB = 16;

  localparam logic [AW-1:0] OFS_REV   = 8'h00;
  localparam logic [AW-1:0] OFS_CTRL  = 8'h04;
  localparam logic [AW-1:0] OFS_STAT  = 8'h08;
  localparam logic [AW-1:0] OFS_RAW   = 8'h20;
  localparam logic [AW-1:0] OFS_SSET  = 8'h24;
  localparam logic [AW-1:0] OFS_SCLR  = 8'h28;
  localparam logic [AW-1:0] OFS_MASK  = 8'h2c;
  localparam logic [AW-1:0] OFS_MSET  = 8'h30;
  localparam logic [AW-1:0] OFS_MCLR  = 8'h34;
  localparam logic [AW-1:0] OFS_MSKD  = 8'h38;
  localparam logic [AW-1:0] OFS_EOI   = 8'h3c;

  function automatic logic [DW-1:0] field_mask(input int lsb, input int n);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < n; i++) m[lsb+i] = 1'b1;
    return m;
  endfunction

  localparam logic [DW-1:0] SRC_KEEP = field_mask(TX_LSB, TX_N) |
                                       field_mask(RX_LSB, RX_N) |
                                       field_mask(CORE_LSB, CORE_N);

  typedef struct packed {
    logic [DW-1:0] src_set;
    logic [DW-1:0] src_clr;
    logic [DW-1:0] msk_set;
    logic [DW-1:0] msk_clr;
    logic          eoi;
  } wr_strobe_t;
endpackage

// File: rtl/irq_agg_bitreg.sv
module irq_agg_bitreg #(
  parameter int             W    = 32,
  parameter logic [W-1:0]   KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] clr_v,
  input  logic [W-1:0] hw_v,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (KEEP[i]) begin : g_live
      logic bit_d, bit_q;
      always_comb begin
        bit_d = bit_q;
        if (flush)                          bit_d = 1'b0;
        else if (set_v[i] || hw_v[i])       bit_d = 1'b1;
        else if (clr_v[i])                  bit_d = 1'b0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
      end
      assign q[i] = bit_q;
    end else begin : g_tie
      assign q[i] = 1'b0;
    end
  end

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && (|clr_v)) |=> ((q & $past(clr_v & ~set_v & ~hw_v)) == '0));
  assert_hw_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && (|(hw_v & KEEP))) |=> ((q & $past(hw_v & KEEP)) == $past(hw_v & KEEP)));
  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && (|(set_v & KEEP))) |=> ((q & $past(set_v & KEEP)) == $past(set_v & KEEP)));
  assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (q == '0));
endmodule

// File: rtl/irq_agg_gate.sv
module irq_agg_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic eoi,
  input  logic pend,
  output logic irq
);
  logic armed_q, armed_d;

  assign irq = armed_q & pend;

  always_comb begin
    armed_d = armed_q;
    if (flush)    armed_d = 1'b1;
    else if (eoi) armed_d = 1'b1;
    else if (irq) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b1;
    else        armed_q <= armed_d;
  end

  assert_quiet_until_eoi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !eoi && !flush) |=> !irq);
  assert_stays_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !eoi && !flush) |=> !irq);
  assert_eoi_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi || flush) |=> armed_q);
endmodule

// File: rtl/irq_agg_regif.sv
module irq_agg_regif
  import irq_agg_pkg::*;
#(
  parameter logic [DW-1:0] REV_ID = 32'h4E10_0201
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] src_q,
  input  logic [DW-1:0] msk_q,
  input  logic          vbus_drv,
  output logic [DW-1:0] bus_rdata,
  output logic          soft_q,
  output wr_strobe_t    stb
);
  logic soft_d;
  logic wr_ok;

  assign wr_ok  = bus_wr & ~soft_q;
  assign soft_d = wr_ok & (bus_addr == OFS_CTRL) & bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soft_q <= 1'b0;
    else        soft_q <= soft_d;
  end

  always_comb begin
    stb         = '0;
    if (wr_ok) begin
      if (bus_addr == OFS_SSET) stb.src_set = bus_wdata & SRC_KEEP;
      if (bus_addr == OFS_SCLR) stb.src_clr = bus_wdata & SRC_KEEP;
      if (bus_addr == OFS_MSET) stb.msk_set = bus_wdata & SRC_KEEP;
      if (bus_addr == OFS_MCLR) stb.msk_clr = bus_wdata & SRC_KEEP;
      if (bus_addr == OFS_EOI)  stb.eoi     = 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_REV:  bus_rdata = REV_ID;
      OFS_CTRL: bus_rdata[0] = soft_q;
      OFS_STAT: bus_rdata[0] = vbus_drv;
      OFS_RAW:  bus_rdata = src_q;
      OFS_MASK: bus_rdata = msk_q;
      OFS_MSKD: bus_rdata = src_q & msk_q;
      default:  bus_rdata = '0;
    endcase
  end

  assert_soft_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_q |=> !soft_q);
  assert_rev_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_REV) |-> (bus_rdata != '0));
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter logic [31:0] REV_ID = 32'h4E10_0201
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [4:0]  tx_evt,
  input  logic [3:0]  rx_evt,
  input  logic [8:0]  core_evt,
  input  logic        vbus_drv,
  output logic        irq_out
);
  logic [DW-1:0] src_q, msk_q, hw_vec;
  logic          soft_q;
  wr_strobe_t    stb;

  always_comb begin
    hw_vec = '0;
    hw_vec[TX_LSB   +: TX_N]   = tx_evt;
    hw_vec[RX_LSB   +: RX_N]   = rx_evt;
    hw_vec[CORE_LSB +: CORE_N] = core_evt;
  end

  irq_agg_regif #(.REV_ID(REV_ID)) u_regif (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .src_q(src_q), .msk_q(msk_q), .vbus_drv(vbus_drv),
    .bus_rdata(bus_rdata), .soft_q(soft_q), .stb(stb)
  );

  irq_agg_bitreg #(.W(DW), .KEEP(SRC_KEEP)) u_src (
    .clk(clk), .rst_n(rst_n), .flush(soft_q), .set_v(stb.src_set),
    .clr_v(stb.src_clr), .hw_v(hw_vec), .q(src_q)
  );

  irq_agg_bitreg #(.W(DW), .KEEP(SRC_KEEP)) u_msk (
    .clk(clk), .rst_n(rst_n), .flush(soft_q), .set_v(stb.msk_set),
    .clr_v(stb.msk_clr), .hw_v({DW{1'b0}}), .q(msk_q)
  );

  irq_agg_gate u_gate (
    .clk(clk), .rst_n(rst_n), .flush(soft_q), .eoi(stb.eoi),
    .pend(|(src_q & msk_q)), .irq(irq_out)
  );

  assert_unused_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_q | msk_q) & ~SRC_KEEP) == '0);
  assert_irq_needs_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|(src_q & msk_q)));
endmodule

// File: tb/irq_agg_top_test.sv
module irq_agg_top_test;
  localparam int          CLK_P = 10;
  localparam logic [31:0] REV   = 32'h4E10_0201;
  localparam logic [31:0] VALID = 32'h01FF_1E1F;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  tx_evt = '0;
  logic [3:0]  rx_evt = '0;
  logic [8:0]  core_evt = '0;
  logic        vbus_drv = 1'b0;
  logic        irq_out;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] m_src = '0, m_msk = '0;
  logic        m_armed = 1'b1, m_soft = 1'b0;

  irq_agg_top #(.REV_ID(REV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_evt(tx_evt),
    .rx_evt(rx_evt), .core_evt(core_evt), .vbus_drv(vbus_drv), .irq_out(irq_out)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
  end

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00: return REV;
      8'h04: return {31'b0, m_soft};
      8'h08: return {31'b0, vbus_drv};
      8'h20: return m_src;
      8'h2c: return m_msk;
      8'h38: return m_src & m_msk;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return m_armed && ((m_src & m_msk) != 0);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    bus_wr = 1'b0; bus_addr = a; #1;
    chk(tag, bus_rdata, exp_rd(a));
  endtask

  // inputs are driven at negedge; the model advances at posedge
  task automatic tick();
    logic [31:0] hw, sset, sclr, mset, mclr;
    logic irq_now, eoi;
    @(posedge clk);
    hw = '0; hw[4:0] = tx_evt; hw[12:9] = rx_evt; hw[24:16] = core_evt;
    irq_now = exp_irq();
    if (m_soft) begin
      m_src = '0; m_msk = '0; m_armed = 1'b1; m_soft = 1'b0;
    end else begin
      sset = (bus_wr && bus_addr == 8'h24) ? bus_wdata & VALID : 32'h0;
      sclr = (bus_wr && bus_addr == 8'h28) ? bus_wdata & VALID : 32'h0;
      mset = (bus_wr && bus_addr == 8'h30) ? bus_wdata & VALID : 32'h0;
      mclr = (bus_wr && bus_addr == 8'h34) ? bus_wdata & VALID : 32'h0;
      eoi  = bus_wr && bus_addr == 8'h3c;
      m_src   = (m_src & ~sclr) | sset | hw;
      m_msk   = (m_msk & ~mclr) | mset;
      m_armed = eoi ? 1'b1 : (irq_now ? 1'b0 : m_armed);
      m_soft  = bus_wr && bus_addr == 8'h04 && bus_wdata[0];
    end
    @(negedge clk);
    bus_wr = 1'b0; tx_evt = '0; rx_evt = '0; core_evt = '0;
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
  endtask

  task automatic irq_chk(input string tag, input logic exp);
    n_cmp++;
    if (irq_out !== exp) begin
      n_bad++;
      $display("FAIL %s: irq actual %0b expected %0b", tag, irq_out, exp);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state, R8 revision
    rd("R9 raw", 8'h20); rd("R9 mask", 8'h2c); irq_chk("R9 irq", 1'b0);
    rd("R8 rev", 8'h00); chk("R8 rev literal", bus_rdata, 32'h4E10_0201);
    vbus_drv = 1'b1; rd("R8 status", 8'h08); chk("R8 status lit", bus_rdata, 32'h1);
    vbus_drv = 1'b0; rd("R8 status low", 8'h08);
    rd("R8 unmapped", 8'h44); rd("R8 eoi reads 0", 8'h3c);
    // R1 field positions
    tx_evt = 5'h1f; tick(); rd("R1 tx", 8'h20); chk("R1 tx lit", bus_rdata, 32'h0000_001F);
    rx_evt = 4'hf; tick(); rd("R1 rx", 8'h20); chk("R1 rx lit", bus_rdata, 32'h0000_1E1F);
    core_evt = 9'h100; tick(); rd("R1 vbus-drive bit24", 8'h20);
    chk("R1 bit24 lit", bus_rdata & 32'h0100_0000, 32'h0100_0000);
    wr(8'h28, 32'hFFFF_FFFF); rd("R3 clear all", 8'h20);
    // R2 set, zero bits no effect, unused bits stay 0
    wr(8'h24, 32'hFFFF_FFFF); rd("R2 set all", 8'h20); chk("R2 lit", bus_rdata, VALID);
    wr(8'h28, 32'hFFFF_FFFF); wr(8'h24, 32'h0000_0004); wr(8'h24, 32'h0);
    rd("R2 zero no effect", 8'h20);
    wr(8'h20, 32'hFFFF_FFFF); rd("R4 raw read-only", 8'h20);
    // R3 hardware wins over same-cycle clear
    bus_wr = 1'b1; bus_addr = 8'h28; bus_wdata = 32'hFFFF_FFFF; tx_evt = 5'h01; tick();
    rd("R3 hw wins", 8'h20); chk("R3 lit", bus_rdata, 32'h1);
    irq_chk("R6 masked off", 1'b0);
    // R4 mask, R5 masked read, R6 gating
    wr(8'h2c, 32'hFFFF_FFFF); rd("R4 mask read-only", 8'h2c);
    wr(8'h30, 32'h0000_0001); rd("R4 mask set", 8'h2c); rd("R5 masked", 8'h38);
    irq_chk("R6 first assert", 1'b1);
    tick(); irq_chk("R6 quiet after one cycle", 1'b0);
    core_evt = 9'h1ff; tick(); wr(8'h30, 32'hFFFF_FFFF);
    irq_chk("R6 quiet despite new events", 1'b0); rd("R5 masked wide", 8'h38);
    wr(8'h3c, 32'h0); irq_chk("R6 rearm by eoi", 1'b1);
    tick(); irq_chk("R6 drop again", 1'b0);
    wr(8'h34, 32'hFFFF_FFFF); rd("R4 mask clear", 8'h2c);
    wr(8'h3c, 32'hDEAD_BEEF); irq_chk("R6 no pend after eoi", 1'b0);
    // R7 soft reset
    wr(8'h30, 32'h0000_00FF); wr(8'h04, 32'h1);
    rd("R7 ctrl reads 1", 8'h04); chk("R7 ctrl lit", bus_rdata, 32'h1);
    bus_wr = 1'b1; bus_addr = 8'h24; bus_wdata = 32'hFFFF_FFFF; tx_evt = 5'h1f; tick();
    rd("R7 src flushed", 8'h20); chk("R7 src lit", bus_rdata, 32'h0);
    rd("R7 mask flushed", 8'h2c); rd("R7 ctrl self-clear", 8'h04);
    irq_chk("R7 irq low", 1'b0);
    // random phase
    for (int it = 0; it < 3000; it++) begin
      int op;
      logic [7:0] ra;
      op = $urandom % 24;
      bus_wdata = $urandom;
      if ($urandom % 3 == 0) bus_wdata = bus_wdata & (32'h1 << ($urandom % 32));
      case (op)
        0, 1, 2:  begin bus_wr = 1'b1; bus_addr = 8'h24; end
        3, 4, 5:  begin bus_wr = 1'b1; bus_addr = 8'h28; end
        6, 7:     begin bus_wr = 1'b1; bus_addr = 8'h30; end
        8:        begin bus_wr = 1'b1; bus_addr = 8'h34; end
        9:        begin bus_wr = 1'b1; bus_addr = 8'h3c; end
        10:       begin bus_wr = ($urandom % 8 == 0); bus_addr = 8'h04; end
        default:  bus_wr = 1'b0;
      endcase
      if ($urandom % 4 == 0) tx_evt = $urandom;
      if ($urandom % 5 == 0) rx_evt = $urandom;
      if ($urandom % 6 == 0) core_evt = $urandom;
      vbus_drv = $urandom;
      tick();
      irq_chk("R6 random irq", exp_irq());
      if (it % 4 == 0) begin
        ra = 8'h04 * ($urandom % 16);
        rd("R5 random read", ra);
      end
    end
    summary();
  end
endmodule